// File: doc/BRIEF.md
# Snooping MESI Cache-Line Controller

This block tracks the coherence state of every line in one core's private cache and keeps it consistent with the other caches on a shared snooping bus. It holds a small directly indexed array. Each entry has a tag, a two-bit coherence state and a single data word, so a line is one word. The core issues loads and stores through a held request and receives a one-cycle response. Hits complete locally. Misses and stores to shared lines become bus transactions that complete only when the external arbiter grants them.

On the snoop side the block watches the transactions of the other cores. It answers a snooped read with a registered shared indication. It gives up or downgrades its copy as the protocol demands. Dirty data leaves through a write-back port to memory, both when a snoop forces it out and when a fill evicts a modified victim.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: Line states are two-bit codes: Invalid 2'b00, Shared 2'b01, Exclusive 2'b10, Modified 2'b11. After reset every line is Invalid, and all of core_resp_valid, bus_req_valid, snoop_shared and mem_wb_valid are low.
- R2: A load miss raises bus_req_valid with bus_req_cmd = 2'b01 (read) the cycle after acceptance. It returns bus_rdata and installs the line Exclusive when bus_shared_in is low at the grant.
- R3: A load miss granted with bus_shared_in high installs the line Shared.
- R4: A load that hits a valid line responds with its stored word the cycle after acceptance and makes no bus request.
- R5: A store that hits an Exclusive or Modified line writes the word and leaves the line Modified with no bus transaction.
- R6: A store that hits a Shared line issues bus_req_cmd = 2'b11 (invalidate). Every bus request keeps bus_req_valid high until bus_gnt, and core_resp_valid rises the cycle after the grant and not before.
- R7: A store miss issues bus_req_cmd = 2'b10 (read for ownership) and installs the line Modified with the store word.
- R8: A snooped read (snoop_cmd = 2'b01) that hits an Exclusive or Shared line raises snoop_shared the next cycle and leaves the line Shared.
- R9: A snooped read that hits a Modified line raises snoop_shared, writes the line's address and word back through mem_wb_* the next cycle, and leaves it Shared.
- R10: A snooped read for ownership (2'b10) or invalidate (2'b11) that hits moves the line to Invalid, writing it back first when it was Modified. It never raises snoop_shared.
- R11: A snoop whose tag differs from the stored one, or that finds the line Invalid, changes nothing and raises neither snoop_shared nor mem_wb_valid.
- R12: A fill that replaces a Modified line of another tag writes the victim back the cycle after the grant. Replacing a clean line writes nothing.
- R13: A snoop in the same cycle as an idle core request is applied first, and the core request is accepted in a later cycle against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Core request, held until the response |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | ADDR_W | Word address of the request |
| core_req_wdata | input | DATA_W | Store word |
| core_resp_valid | output | 1 | One-cycle completion pulse |
| core_resp_rdata | output | DATA_W | Load result (store word on stores) |
| bus_req_valid | output | 1 | Bus transaction pending |
| bus_req_cmd | output | 2 | 01 read, 10 read for ownership, 11 invalidate |
| bus_req_addr | output | ADDR_W | Address of the pending transaction |
| bus_gnt | input | 1 | Grant; the transaction completes this cycle |
| bus_rdata | input | DATA_W | Line word supplied with the grant |
| bus_shared_in | input | 1 | Another cache holds the line (read grants) |
| snoop_valid | input | 1 | Another core's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command, same codes as bus_req_cmd |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_shared | output | 1 | This cache holds the snooped line (read) |
| mem_wb_valid | output | 1 | Write-back to memory |
| mem_wb_addr | output | ADDR_W | Write-back address |
| mem_wb_data | output | DATA_W | Write-back word |

## Verification
The bench aims at the state-dependent paths whose errors stay hidden until a later access. One case is a store right after an unshared fill: a design that filled Shared would issue a needless invalidate there. Another is a snooped read of a dirty line: a design that only downgraded it would lose the word, and the bench's memory model would return the stale value on the next miss. Evictions are tried with both a dirty and a clean victim, to catch a missing write-back or a spurious one. A snoop that collides with a new core request to the same line checks ordering: a design that served the core first would report a hit on a line it had just lost.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE  = 2'b00,
    BC_READ  = 2'b01,
    BC_RDOWN = 2'b10,
    BC_UPGR  = 2'b11
  } bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_t          a_st,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_t          b_st,
  output logic [DATA_W-1:0] b_data,
  input  logic              meta_we,
  input  logic              data_we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [TAG_W-1:0]  w_tag,
  input  line_st_t          w_st,
  input  logic [DATA_W-1:0] w_data
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];
  line_st_t          st_mem   [LINES];

  // Tags and data carry no reset so they map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (meta_we) tag_mem[w_idx] <= w_tag;
    if (data_we) data_mem[w_idx] <= w_data;
  end

  // Only the state bits need a defined value after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_mem[i] <= ST_I;
    end else if (meta_we) begin
      st_mem[w_idx] <= w_st;
    end
  end

  assign a_tag  = tag_mem[a_idx];
  assign a_st   = st_mem[a_idx];
  assign a_data = data_mem[a_idx];
  assign b_tag  = tag_mem[b_idx];
  assign b_st   = st_mem[b_idx];
  assign b_data = data_mem[b_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             snp_valid,
  input  bus_cmd_t         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_t         line_st,
  output logic             hit,
  output logic             upd,
  output line_st_t         nxt_st,
  output logic             give_shared,
  output logic             need_wb
);
  always_comb begin
    hit         = snp_valid && (snp_cmd != BC_NONE) && (line_st != ST_I) && (line_tag == snp_tag);
    upd         = 1'b0;
    nxt_st      = line_st;
    give_shared = 1'b0;
    need_wb     = 1'b0;
    if (hit) begin
      upd     = 1'b1;
      need_wb = (line_st == ST_M);
      if (snp_cmd == BC_READ) begin
        nxt_st      = ST_S;
        give_shared = 1'b1;
      end else begin
        nxt_st = ST_I;
      end
    end
  end
endmodule

// File: rtl/mesi_core_decide.sv
module mesi_core_decide
  import mesi_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             is_wr,
  input  logic             shared_in,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_t         line_st,
  output logic             hit,
  output logic             local_ok,
  output bus_cmd_t         need_cmd,
  output line_st_t         fill_st,
  output logic             victim_dirty
);
  always_comb begin
    hit          = (line_st != ST_I) && (line_tag == req_tag);
    local_ok     = is_wr ? (hit && (line_st == ST_E || line_st == ST_M)) : hit;
    need_cmd     = !is_wr ? BC_READ : (hit ? BC_UPGR : BC_RDOWN);
    fill_st      = is_wr ? ST_M : (shared_in ? ST_S : ST_E);
    victim_dirty = (line_st == ST_M) && !hit;
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req_valid,
  input  logic              core_req_write,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_resp_valid,
  output logic [DATA_W-1:0] core_resp_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared,
  output logic              mem_wb_valid,
  output logic [ADDR_W-1:0] mem_wb_addr,
  output logic [DATA_W-1:0] mem_wb_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {FS_IDLE, FS_WAIT, FS_RESP} fsm_t;

  fsm_t              fs_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_wr_q;
  logic [DATA_W-1:0] req_wdata_q;

  // Core side sees live inputs while idle and the latched request afterwards.
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_wr;
  logic [DATA_W-1:0] cur_wdata;
  assign cur_addr  = (fs_q == FS_IDLE) ? core_req_addr  : req_addr_q;
  assign cur_wr    = (fs_q == FS_IDLE) ? core_req_write : req_wr_q;
  assign cur_wdata = (fs_q == FS_IDLE) ? core_req_wdata : req_wdata_q;

  logic [IDX_W-1:0] cur_idx, snp_idx;
  logic [TAG_W-1:0] cur_tag, snp_tag;
  assign cur_idx = cur_addr[IDX_W-1:0];
  assign cur_tag = cur_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snoop_addr[IDX_W-1:0];
  assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_t          a_st, b_st;
  logic [DATA_W-1:0] a_data, b_data;
  logic              meta_we, data_we;
  logic [IDX_W-1:0]  w_idx;
  logic [TAG_W-1:0]  w_tag;
  line_st_t          w_st;
  logic [DATA_W-1:0] w_data;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .a_idx  (cur_idx),
    .a_tag  (a_tag),
    .a_st   (a_st),
    .a_data (a_data),
    .b_idx  (snp_idx),
    .b_tag  (b_tag),
    .b_st   (b_st),
    .b_data (b_data),
    .meta_we(meta_we),
    .data_we(data_we),
    .w_idx  (w_idx),
    .w_tag  (w_tag),
    .w_st   (w_st),
    .w_data (w_data)
  );

  logic     snp_hit, snp_upd, snp_give_shared, snp_need_wb;
  line_st_t snp_nxt;

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid  (snoop_valid),
    .snp_cmd    (bus_cmd_t'(snoop_cmd)),
    .snp_tag    (snp_tag),
    .line_tag   (b_tag),
    .line_st    (b_st),
    .hit        (snp_hit),
    .upd        (snp_upd),
    .nxt_st     (snp_nxt),
    .give_shared(snp_give_shared),
    .need_wb    (snp_need_wb)
  );

  logic     core_hit, core_local, victim_dirty;
  bus_cmd_t core_cmd;
  line_st_t fill_st;

  mesi_core_decide #(.TAG_W(TAG_W)) u_decide (
    .is_wr       (cur_wr),
    .shared_in   (bus_shared_in),
    .req_tag     (cur_tag),
    .line_tag    (a_tag),
    .line_st     (a_st),
    .hit         (core_hit),
    .local_ok    (core_local),
    .need_cmd    (core_cmd),
    .fill_st     (fill_st),
    .victim_dirty(victim_dirty)
  );

  logic core_accept, grant_now;
  assign core_accept = (fs_q == FS_IDLE) && core_req_valid && !snoop_valid;
  assign grant_now   = (fs_q == FS_WAIT) && bus_gnt;

  // Single write port: a snoop update wins, then a local store hit, then a fill.
  always_comb begin
    meta_we = 1'b0;
    data_we = 1'b0;
    w_idx   = cur_idx;
    w_tag   = cur_tag;
    w_st    = a_st;
    w_data  = cur_wdata;
    if (snp_upd) begin
      meta_we = 1'b1;
      w_idx   = snp_idx;
      w_tag   = b_tag;
      w_st    = snp_nxt;
    end else if (core_accept && core_local && cur_wr) begin
      meta_we = 1'b1;
      data_we = 1'b1;
      w_st    = ST_M;
    end else if (grant_now) begin
      meta_we = 1'b1;
      data_we = 1'b1;
      w_st    = fill_st;
      w_data  = cur_wr ? cur_wdata : bus_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q            <= FS_IDLE;
      req_addr_q      <= '0;
      req_wr_q        <= 1'b0;
      req_wdata_q     <= '0;
      core_resp_valid <= 1'b0;
      core_resp_rdata <= '0;
      bus_req_valid   <= 1'b0;
      bus_req_cmd     <= BC_NONE;
      bus_req_addr    <= '0;
      snoop_shared    <= 1'b0;
      mem_wb_valid    <= 1'b0;
      mem_wb_addr     <= '0;
      mem_wb_data     <= '0;
    end else begin
      core_resp_valid <= 1'b0;
      mem_wb_valid    <= 1'b0;
      snoop_shared    <= snp_give_shared;
      if (snp_need_wb) begin
        mem_wb_valid <= 1'b1;
        mem_wb_addr  <= {b_tag, snp_idx};
        mem_wb_data  <= b_data;
      end
      unique case (fs_q)
        FS_IDLE: begin
          if (core_accept) begin
            req_addr_q  <= core_req_addr;
            req_wr_q    <= core_req_write;
            req_wdata_q <= core_req_wdata;
            if (core_local) begin
              core_resp_valid <= 1'b1;
              core_resp_rdata <= core_req_write ? core_req_wdata : a_data;
              fs_q            <= FS_RESP;
            end else begin
              bus_req_valid <= 1'b1;
              bus_req_cmd   <= core_cmd;
              bus_req_addr  <= core_req_addr;
              fs_q          <= FS_WAIT;
            end
          end
        end
        FS_WAIT: begin
          if (bus_gnt) begin
            bus_req_valid   <= 1'b0;
            bus_req_cmd     <= BC_NONE;
            core_resp_valid <= 1'b1;
            core_resp_rdata <= req_wr_q ? req_wdata_q : bus_rdata;
            if (victim_dirty) begin
              mem_wb_valid <= 1'b1;
              mem_wb_addr  <= {a_tag, cur_idx};
              mem_wb_data  <= a_data;
            end
            fs_q <= FS_RESP;
          end
        end
        default: fs_q <= FS_IDLE;
      endcase
    end
  end

  // R6: the arbiter only grants a pending request, and completion follows at once.
  assert_gnt_only_when_pending_R6: assert property (@(posedge clk) disable iff (rst)
    bus_gnt |-> (bus_req_valid && fs_q == FS_WAIT));
  assert_resp_after_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (fs_q == FS_WAIT && bus_gnt) |=> (core_resp_valid && !bus_req_valid));
  // R5: a store to an Exclusive line completes with no bus traffic.
  assert_silent_upgrade_R5: assert property (@(posedge clk) disable iff (rst)
    (core_accept && core_req_write && core_hit && a_st == ST_E) |=> (core_resp_valid && !bus_req_valid));
  // R8: a snooped read that hits is answered with the shared indication.
  assert_read_snoop_shared_R8: assert property (@(posedge clk) disable iff (rst)
    (snp_hit && snoop_cmd == BC_READ) |=> snoop_shared);
  // R9: a dirty snooped line leaves through the write-back port with its own address.
  assert_dirty_snoop_wb_R9: assert property (@(posedge clk) disable iff (rst)
    (snp_hit && b_st == ST_M) |=> (mem_wb_valid && mem_wb_addr == $past(snoop_addr)));
  // R12: the bus never grants this cache while another core's transaction is snooped.
  assert_no_snoop_in_grant_R12: assert property (@(posedge clk) disable iff (rst)
    !(bus_gnt && snoop_valid));
  // R13: an idle controller that sees a snoop stays idle for that cycle.
  assert_snoop_first_R13: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && fs_q == FS_IDLE) |=> (fs_q == FS_IDLE));
endmodule

// File: tb/test_mesi_snoop_ctrl.sv
module test_mesi_snoop_ctrl;
  localparam int ADDR_W    = 12;
  localparam int IDX_W     = 4;
  localparam int DATA_W    = 32;
  localparam int GNT_DELAY = 3;
  localparam logic [1:0] C_RD = 2'b01, C_RDX = 2'b10, C_UPG = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              core_req_valid = 0, core_req_write = 0;
  logic [ADDR_W-1:0] core_req_addr = '0;
  logic [DATA_W-1:0] core_req_wdata = '0;
  logic              core_resp_valid;
  logic [DATA_W-1:0] core_resp_rdata;
  logic              bus_req_valid;
  logic [1:0]        bus_req_cmd;
  logic [ADDR_W-1:0] bus_req_addr;
  logic              bus_gnt = 0, bus_shared_in = 0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              snoop_valid = 0;
  logic [1:0]        snoop_cmd = '0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic              snoop_shared, mem_wb_valid;
  logic [ADDR_W-1:0] mem_wb_addr;
  logic [DATA_W-1:0] mem_wb_data;

  mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_mesi_snoop_ctrl (
    .clk(clk), .rst(rst),
    .core_req_valid(core_req_valid), .core_req_write(core_req_write),
    .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
    .core_resp_valid(core_resp_valid), .core_resp_rdata(core_resp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .snoop_shared(snoop_shared),
    .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data)
  );

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  int wb_cnt = 0;
  logic [ADDR_W-1:0] last_wb_addr = '0;
  logic [DATA_W-1:0] last_wb_data = '0;

  // Memory model: absorbs every write-back.
  always @(negedge clk) begin
    if (!rst && mem_wb_valid) begin
      mem[mem_wb_addr] = mem_wb_data;
      wb_cnt++;
      last_wb_addr = mem_wb_addr;
      last_wb_data = mem_wb_data;
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One core access; the bench acts as bus arbiter and memory.
  task automatic core_op(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                         input logic oth_sh, input logic with_snp, input logic [1:0] scmd,
                         output logic [DATA_W-1:0] rd, output logic used, output logic [1:0] cmd,
                         output logic early);
    int n = 0;
    int waits = 0;
    logic granted = 0;
    used = 0; cmd = 2'b00; early = 0; rd = '0;
    @(negedge clk);
    core_req_valid = 1; core_req_write = wr; core_req_addr = a; core_req_wdata = wd;
    if (with_snp) begin snoop_valid = 1; snoop_cmd = scmd; snoop_addr = a; end
    forever begin
      @(negedge clk);
      snoop_valid = 0;
      bus_gnt = 0;
      if (bus_req_valid && !granted && !used) begin used = 1; cmd = bus_req_cmd; end
      if (core_resp_valid) begin
        early = used && !granted;
        rd = core_resp_rdata;
        break;
      end
      if (bus_req_valid && !granted) begin
        waits++;
        if (waits == GNT_DELAY) begin
          bus_gnt = 1; bus_rdata = mem[bus_req_addr]; bus_shared_in = oth_sh; granted = 1;
        end
      end
      n++;
      if (n > 60) begin
        check(1'b0, "R6", "core request hung", 0, 1);
        break;
      end
    end
    core_req_valid = 0; bus_shared_in = 0;
    @(negedge clk);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a, output logic sh,
                       output logic wbv, output logic [ADDR_W-1:0] wa, output logic [DATA_W-1:0] wd);
    @(negedge clk);
    snoop_valid = 1; snoop_cmd = c; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 0;
    sh = snoop_shared; wbv = mem_wb_valid; wa = mem_wb_addr; wd = mem_wb_data;
    @(negedge clk);
  endtask

  logic [DATA_W-1:0] rd, swd;
  logic used, early, sh, wbv;
  logic [1:0] cmd;
  logic [ADDR_W-1:0] swa;

  task automatic t_reset_and_fill();
    check(!core_resp_valid && !bus_req_valid && !snoop_shared && !mem_wb_valid, "R1",
          "outputs after reset", {core_resp_valid, bus_req_valid, snoop_shared, mem_wb_valid}, 0);
    core_op(0, 12'h013, 0, 0, 0, 0, rd, used, cmd, early);
    check(used, "R1", "load after reset misses", used, 1);
    check(cmd == C_RD, "R2", "load miss command", cmd, C_RD);
    check(rd == 32'hA500_0013, "R2", "load miss data", rd, 32'hA500_0013);
  endtask

  task automatic t_silent_store();
    core_op(1, 12'h013, 32'h1234_5678, 0, 0, 0, rd, used, cmd, early);
    check(!used, "R2", "store after unshared fill needs no bus (Exclusive)", used, 0);
    core_op(1, 12'h013, 32'h1111_2222, 0, 0, 0, rd, used, cmd, early);
    check(!used, "R5", "store to Modified line needs no bus", used, 0);
    core_op(0, 12'h013, 0, 0, 0, 0, rd, used, cmd, early);
    check(!used && rd == 32'h1111_2222, "R4", "load hit data", rd, 32'h1111_2222);
  endtask

  task automatic t_shared_fill();
    core_op(0, 12'h045, 0, 1, 0, 0, rd, used, cmd, early);
    check(rd == 32'hA500_0045, "R3", "shared fill data", rd, 32'hA500_0045);
    core_op(1, 12'h045, 32'hBBBB_0001, 0, 0, 0, rd, used, cmd, early);
    check(used && cmd == C_UPG, "R3", "store to Shared line issues invalidate", cmd, C_UPG);
    check(!early, "R6", "store completes only after grant", early, 0);
    core_op(0, 12'h045, 0, 0, 0, 0, rd, used, cmd, early);
    check(!used && rd == 32'hBBBB_0001, "R4", "load hit after upgrade", rd, 32'hBBBB_0001);
  endtask

  task automatic t_store_miss();
    core_op(1, 12'h067, 32'hCCCC_0067, 0, 0, 0, rd, used, cmd, early);
    check(used && cmd == C_RDX, "R7", "store miss command", cmd, C_RDX);
    check(!early, "R6", "store miss waits for grant", early, 0);
    core_op(0, 12'h067, 0, 0, 0, 0, rd, used, cmd, early);
    check(!used && rd == 32'hCCCC_0067, "R7", "store miss installed word", rd, 32'hCCCC_0067);
  endtask

  task automatic t_snoop_read_clean();
    core_op(0, 12'h089, 0, 0, 0, 0, rd, used, cmd, early);
    snoop(C_RD, 12'h089, sh, wbv, swa, swd);
    check(sh, "R8", "shared answer on Exclusive line", sh, 1);
    check(!wbv, "R8", "no write-back from clean line", wbv, 0);
    core_op(1, 12'h089, 32'hDDDD_0089, 0, 0, 0, rd, used, cmd, early);
    check(used && cmd == C_UPG, "R8", "line downgraded to Shared", cmd, C_UPG);
  endtask

  task automatic t_snoop_read_dirty();
    snoop(C_RD, 12'h013, sh, wbv, swa, swd);
    check(sh, "R9", "shared answer on Modified line", sh, 1);
    check(wbv && swa == 12'h013, "R9", "write-back address", swa, 12'h013);
    check(swd == 32'h1111_2222, "R9", "write-back data", swd, 32'h1111_2222);
    core_op(1, 12'h013, 32'h3333_0013, 0, 0, 0, rd, used, cmd, early);
    check(used && cmd == C_UPG, "R9", "dirty line left Shared", cmd, C_UPG);
  endtask

  task automatic t_snoop_invalidate();
    snoop(C_RDX, 12'h013, sh, wbv, swa, swd);
    check(!sh, "R10", "no shared answer on ownership snoop", sh, 0);
    check(wbv && swd == 32'h3333_0013, "R10", "dirty data written back", swd, 32'h3333_0013);
    core_op(0, 12'h013, 0, 0, 0, 0, rd, used, cmd, early);
    check(used && rd == 32'h3333_0013, "R10", "line invalid, refetch sees written-back word", rd, 32'h3333_0013);
    core_op(0, 12'h0AB, 0, 0, 0, 0, rd, used, cmd, early);
    snoop(C_UPG, 12'h0AB, sh, wbv, swa, swd);
    check(!sh && !wbv, "R10", "invalidate of clean line quiet", {sh, wbv}, 0);
    core_op(0, 12'h0AB, 0, 0, 0, 0, rd, used, cmd, early);
    check(used, "R10", "line invalid after invalidate snoop", used, 1);
  endtask

  task automatic t_snoop_miss();
    snoop(C_RDX, 12'h167, sh, wbv, swa, swd);
    check(!sh && !wbv, "R11", "tag mismatch snoop quiet", {sh, wbv}, 0);
    snoop(C_RD, 12'h00F, sh, wbv, swa, swd);
    check(!sh && !wbv, "R11", "snoop of Invalid line quiet", {sh, wbv}, 0);
    core_op(1, 12'h067, 32'hCCCC_1111, 0, 0, 0, rd, used, cmd, early);
    check(!used, "R11", "line kept Modified after foreign snoop", used, 0);
  endtask

  task automatic t_evict();
    int w0 = wb_cnt;
    core_op(0, 12'h167, 0, 0, 0, 0, rd, used, cmd, early);
    check(rd == 32'hA500_0167, "R12", "fill data over dirty victim", rd, 32'hA500_0167);
    check(wb_cnt == w0 + 1, "R12", "dirty victim write-back count", wb_cnt - w0, 1);
    check(last_wb_addr == 12'h067 && last_wb_data == 32'hCCCC_1111, "R12", "victim address/data",
          {last_wb_addr, last_wb_data}, {12'h067, 32'hCCCC_1111});
    w0 = wb_cnt;
    core_op(0, 12'h267, 0, 0, 0, 0, rd, used, cmd, early);
    check(wb_cnt == w0, "R12", "clean victim silent", wb_cnt - w0, 0);
  endtask

  task automatic t_priority();
    int w0 = wb_cnt;
    core_op(0, 12'h267, 0, 0, 1, C_RDX, rd, used, cmd, early);
    check(used, "R13", "snoop applied before colliding core load", used, 1);
    check(rd == 32'hA500_0267, "R13", "load data after refetch", rd, 32'hA500_0267);
    check(wb_cnt == w0, "R13", "clean line dropped without write-back", wb_cnt - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 32'hA500_0000 | i;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_and_fill();
    t_silent_store();
    t_shared_fill();
    t_store_miss();
    t_snoop_read_clean();
    t_snoop_read_dirty();
    t_snoop_invalidate();
    t_snoop_miss();
    t_evict();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule